// File: doc/BRIEF.md
# Single-Pin Serial EEPROM Page Write Sequencer

This block sits on the host side of a serial EEPROM that has one bidirectional data pin and three active-low strobes: a chip select, a read strobe and a write strobe. One start request carries a 16-bit target address and a byte count. The block then runs the whole page-program transaction with ordinary bus cycles. It pulses a reset-step strobe, then shifts the address out one bit per write cycle. Next it shifts the payload bytes out the same way, pulling each byte from the host through an index and take-strobe interface. It then issues a read, write-one, read trigger and polls the data pin with read cycles until the memory reports that it is no longer busy.

Every bus cycle holds its strobes low for a fixed number of clocks and is followed by idle clocks with all strobes high. The protocol has no timing limits, so the pacing is set only by the host clock and two parameters. Requests with an illegal byte count are refused with a one-clock error pulse, and the memory bus stays quiet.

Top module: `pew_sequencer`

## Requirements
- R1: When idle, a request with a byte count from 1 to 32 is accepted on the clock edge where `req_valid` is high. `busy` is high from the next cycle. `rst_step` pulses for exactly one clock before the first bus cycle of the transaction.
- R2: A request whose count is 0 or greater than 32 raises `err` for exactly one clock. It leaves `busy` low and starts no bus cycle.
- R3: The first 16 bus cycles are write cycles, with select and write strobe low and read strobe high. They carry the address on `mem_dq_o`, bit 15 first and bit 0 last.
- R4: Directly after the address come count×8 write cycles, with no read cycle among them. They carry byte 0 to byte count−1, each with bit 7 first. Each byte is captured from `byte_data` in the cycle where `byte_take` is high, and `byte_sel` gives its index, in ascending order from 0.
- R5: After the last data bit the sequencer issues a read cycle, then a write cycle that drives 1, then a read cycle.
- R6: The sequencer then repeats read cycles while the sampled `mem_dq_i` is 0. The pin is sampled on the last clock of the read strobe. After the first read that samples 1, `done` pulses for one clock and `busy` falls on the following cycle.
- R7: Each bus cycle holds select low for STROBE_CLKS clocks (default 2) with a steady strobe type and data bit. It is followed by at least one clock with select high.
- R8: `mem_dq_oe` is high only while a write strobe is low. During read cycles and between cycles the pin is released.
- R9: A request presented while `busy` is high is ignored. The running transaction's address, data and length are unchanged.
- R10: After reset all three strobes are high, `mem_dq_oe` is low, and `busy`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start request strobe |
| req_addr | input | 16 | Target address of the page write |
| req_count | input | 6 | Number of bytes to load (1 to 32 legal) |
| byte_sel | output | 5 | Index of the byte to capture next |
| byte_take | output | 1 | Byte at `byte_sel` is captured this cycle |
| byte_data | input | 8 | Host payload byte selected by `byte_sel` |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-clock pulse at transaction end |
| err | output | 1 | One-clock pulse on a refused request |
| rst_step | output | 1 | One-clock reset-step strobe |
| mem_sel_n | output | 1 | Memory chip select, active low |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| mem_dq_o | output | 1 | Data pin output value |
| mem_dq_oe | output | 1 | Data pin output enable |
| mem_dq_i | input | 1 | Data pin input value |

## Verification
The properties assume that reset is held low for at least one clock before operation. They also assume that `mem_dq_i` is only meaningful during read strobes. Nothing is assumed about the request inputs: requests may arrive at any time, including while busy. The stimulus exploits that by intruding a second request in the middle of a transaction. The bench drives `mem_dq_i` only at the start of each read cycle, well ahead of the sampling clock. It answers a chosen number of busy polls with 0 before returning 1, so the poll loop always ends.

// File: rtl/pew_pkg.sv
// Package: shared state encodings for the page write sequencer.
// Assumes nothing; only types and fixed widths live here.
package pew_pkg;

    localparam int BYTE_BITS = 8;

    // Transaction steps, in the order the protocol visits them.
    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_RST,
        SQ_ADDR,
        SQ_DATA,
        SQ_TRG_RD0,
        SQ_TRG_WR1,
        SQ_TRG_RD1,
        SQ_POLL,
        SQ_FIN
    } seq_state_e;

    // Phases of one bus cycle.
    typedef enum logic [1:0] {
        BC_IDLE,
        BC_STRB,
        BC_GAP
    } bus_phase_e;

endpackage

// File: rtl/pew_shreg.sv
// Module: left-shifting register presenting its MSB.
// Does: parallel load (priority) or shift toward the MSB by one.
// Assumes: load and shift are single-cycle controls from the sequencer.
module pew_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic         msb
);

    logic [W-1:0] sr_q;

    // Hold, load or shift the serial word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load) begin
            sr_q <= din;
        end else if (shift) begin
            sr_q <= {sr_q[W-2:0], 1'b0};
        end
    end

    assign msb = sr_q[W-1];

endmodule

// File: rtl/pew_bus_cycle.sv
// Module: one memory bus cycle engine.
// Does: on a start in idle, holds select and either the read or the write
//   strobe low for STROBE_CLKS clocks. It then keeps all strobes high for
//   GAP_CLKS clocks and flags completion on the last of them. Read cycles
//   sample the data pin on the last strobe clock.
// Assumes: STROBE_CLKS >= 1, GAP_CLKS >= 1; start is only given when idle.
module pew_bus_cycle
    import pew_pkg::*;
#(
    parameter int STROBE_CLKS = 2,
    parameter int GAP_CLKS    = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_start,
    input  logic cyc_write,
    input  logic cyc_bit,
    input  logic dq_i,
    output logic idle,
    output logic cyc_done,
    output logic rd_bit,
    output logic sel_n,
    output logic rd_n,
    output logic wr_n,
    output logic dq_o,
    output logic dq_oe
);

    localparam int CW = $clog2(STROBE_CLKS + GAP_CLKS) + 1;

    bus_phase_e   phase_q;
    logic [CW-1:0] cnt_q;
    logic          wr_q;
    logic          bit_q;
    logic          rd_q;
    logic          last_strb;
    logic          last_gap;

    assign last_strb = (cnt_q == CW'(STROBE_CLKS - 1));
    assign last_gap  = (cnt_q == CW'(GAP_CLKS - 1));

    // Phase sequencing, strobe width and gap counting, read sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= BC_IDLE;
            cnt_q   <= '0;
            wr_q    <= 1'b0;
            bit_q   <= 1'b0;
            rd_q    <= 1'b0;
        end else begin
            case (phase_q)
                BC_IDLE: begin
                    if (cyc_start) begin
                        phase_q <= BC_STRB;
                        cnt_q   <= '0;
                        wr_q    <= cyc_write;
                        bit_q   <= cyc_bit;
                    end
                end
                BC_STRB: begin
                    if (last_strb) begin
                        phase_q <= BC_GAP;
                        cnt_q   <= '0;
                        if (!wr_q) begin
                            rd_q <= dq_i;
                        end
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                BC_GAP: begin
                    if (last_gap) begin
                        phase_q <= BC_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                default: phase_q <= BC_IDLE;
            endcase
        end
    end

    // Pin and handshake decode from the registered phase.
    always_comb begin
        idle     = (phase_q == BC_IDLE);
        cyc_done = (phase_q == BC_GAP) && last_gap;
        sel_n    = (phase_q != BC_STRB);
        wr_n     = !((phase_q == BC_STRB) && wr_q);
        rd_n     = !((phase_q == BC_STRB) && !wr_q);
        dq_oe    = (phase_q == BC_STRB) && wr_q;
        dq_o     = dq_oe && bit_q;
        rd_bit   = rd_q;
    end

endmodule

// File: rtl/pew_ctrl.sv
// Module: transaction controller.
// Does: accepts or refuses requests and walks through the reset step,
//   address bits, data bits, trigger cycles and busy polling. It launches
//   one bus cycle at a time on the engine and drives the shift registers
//   and the host byte interface.
// Assumes: the engine raises cyc_done exactly once per launched cycle, and
//   byte_data is valid for byte_sel whenever byte_take is high.
module pew_ctrl
    import pew_pkg::*;
#(
    parameter  int ADDR_W    = 16,
    parameter  int MAX_BYTES = 32,
    localparam int CNT_W     = $clog2(MAX_BYTES + 1),
    localparam int SEL_W     = $clog2(MAX_BYTES),
    localparam int BIT_W     = $clog2(ADDR_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [CNT_W-1:0] req_count,
    input  logic             eng_idle,
    input  logic             cyc_done,
    input  logic             rd_bit,
    input  logic             addr_msb,
    input  logic             data_msb,
    output logic             cyc_start,
    output logic             cyc_write,
    output logic             cyc_bit,
    output logic             addr_load,
    output logic             addr_shift,
    output logic             data_load,
    output logic             data_shift,
    output logic [SEL_W-1:0] byte_sel,
    output logic             byte_take,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             rst_step
);

    seq_state_e       state_q;
    logic [BIT_W-1:0] bit_cnt_q;
    logic [CNT_W-1:0] byte_idx_q;
    logic [CNT_W-1:0] count_q;
    logic             inflight_q;
    logic             err_q;
    logic             count_ok;
    logic             accept;
    logic             bus_state;
    logic             addr_last;
    logic             byte_last_bit;
    logic             last_byte;

    assign count_ok      = (req_count != '0) && (req_count <= CNT_W'(MAX_BYTES));
    assign accept        = (state_q == SQ_IDLE) && req_valid && count_ok;
    assign addr_last     = (bit_cnt_q == BIT_W'(ADDR_W - 1));
    assign byte_last_bit = (bit_cnt_q == BIT_W'(BYTE_BITS - 1));
    assign last_byte     = (byte_idx_q == count_q);

    // Which steps run bus cycles.
    always_comb begin
        case (state_q)
            SQ_ADDR, SQ_DATA, SQ_TRG_RD0, SQ_TRG_WR1, SQ_TRG_RD1, SQ_POLL:
                bus_state = 1'b1;
            default:
                bus_state = 1'b0;
        endcase
    end

    // Cycle launch, type and bit for the current step.
    always_comb begin
        cyc_start = bus_state && eng_idle && !inflight_q;
        cyc_write = (state_q == SQ_ADDR) || (state_q == SQ_DATA) ||
                    (state_q == SQ_TRG_WR1);
        case (state_q)
            SQ_ADDR:    cyc_bit = addr_msb;
            SQ_DATA:    cyc_bit = data_msb;
            SQ_TRG_WR1: cyc_bit = 1'b1;
            default:    cyc_bit = 1'b0;
        endcase
    end

    // Shift register and host byte controls.
    always_comb begin
        addr_load  = accept;
        addr_shift = cyc_done && (state_q == SQ_ADDR);
        data_shift = cyc_done && (state_q == SQ_DATA);
        byte_take  = cyc_done &&
                     (((state_q == SQ_ADDR) && addr_last) ||
                      ((state_q == SQ_DATA) && byte_last_bit && !last_byte));
        data_load  = byte_take;
        byte_sel   = byte_idx_q[SEL_W-1:0];
    end

    // Step sequencing, bit and byte counting, request handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SQ_IDLE;
            bit_cnt_q  <= '0;
            byte_idx_q <= '0;
            count_q    <= '0;
            inflight_q <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            err_q <= 1'b0;
            if (cyc_start) begin
                inflight_q <= 1'b1;
            end else if (cyc_done) begin
                inflight_q <= 1'b0;
            end
            case (state_q)
                SQ_IDLE: begin
                    if (req_valid) begin
                        if (count_ok) begin
                            state_q    <= SQ_RST;
                            count_q    <= req_count;
                            byte_idx_q <= '0;
                            bit_cnt_q  <= '0;
                        end else begin
                            err_q <= 1'b1;
                        end
                    end
                end
                SQ_RST: state_q <= SQ_ADDR;
                SQ_ADDR: begin
                    if (cyc_done) begin
                        if (addr_last) begin
                            bit_cnt_q  <= '0;
                            byte_idx_q <= byte_idx_q + CNT_W'(1);
                            state_q    <= SQ_DATA;
                        end else begin
                            bit_cnt_q <= bit_cnt_q + BIT_W'(1);
                        end
                    end
                end
                SQ_DATA: begin
                    if (cyc_done) begin
                        if (byte_last_bit) begin
                            bit_cnt_q <= '0;
                            if (last_byte) begin
                                state_q <= SQ_TRG_RD0;
                            end else begin
                                byte_idx_q <= byte_idx_q + CNT_W'(1);
                            end
                        end else begin
                            bit_cnt_q <= bit_cnt_q + BIT_W'(1);
                        end
                    end
                end
                SQ_TRG_RD0: if (cyc_done) state_q <= SQ_TRG_WR1;
                SQ_TRG_WR1: if (cyc_done) state_q <= SQ_TRG_RD1;
                SQ_TRG_RD1: if (cyc_done) state_q <= SQ_POLL;
                SQ_POLL:    if (cyc_done && rd_bit) state_q <= SQ_FIN;
                SQ_FIN:     state_q <= SQ_IDLE;
                default:    state_q <= SQ_IDLE;
            endcase
        end
    end

    // Status decode.
    always_comb begin
        busy     = (state_q != SQ_IDLE);
        done     = (state_q == SQ_FIN);
        err      = err_q;
        rst_step = (state_q == SQ_RST);
    end

endmodule

// File: rtl/pew_sequencer.sv
// Module: top of the single-pin EEPROM page write sequencer.
// Does: ties the controller, the bus cycle engine and the address and data
//   shift registers together.
// Assumes: host byte_data follows byte_sel combinationally; mem_dq_i
//   reflects the memory pin while the output enable is low.
module pew_sequencer
    import pew_pkg::*;
#(
    parameter  int ADDR_W      = 16,
    parameter  int MAX_BYTES   = 32,
    parameter  int STROBE_CLKS = 2,
    parameter  int GAP_CLKS    = 1,
    localparam int CNT_W       = $clog2(MAX_BYTES + 1),
    localparam int SEL_W       = $clog2(MAX_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [CNT_W-1:0]     req_count,
    output logic [SEL_W-1:0]     byte_sel,
    output logic                 byte_take,
    input  logic [BYTE_BITS-1:0] byte_data,
    output logic                 busy,
    output logic                 done,
    output logic                 err,
    output logic                 rst_step,
    output logic                 mem_sel_n,
    output logic                 mem_rd_n,
    output logic                 mem_wr_n,
    output logic                 mem_dq_o,
    output logic                 mem_dq_oe,
    input  logic                 mem_dq_i
);

    logic eng_idle;
    logic cyc_done;
    logic rd_bit;
    logic cyc_start;
    logic cyc_write;
    logic cyc_bit;
    logic addr_load;
    logic addr_shift;
    logic data_load;
    logic data_shift;
    logic addr_msb;
    logic data_msb;

    pew_ctrl #(
        .ADDR_W    (ADDR_W),
        .MAX_BYTES (MAX_BYTES)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_count  (req_count),
        .eng_idle   (eng_idle),
        .cyc_done   (cyc_done),
        .rd_bit     (rd_bit),
        .addr_msb   (addr_msb),
        .data_msb   (data_msb),
        .cyc_start  (cyc_start),
        .cyc_write  (cyc_write),
        .cyc_bit    (cyc_bit),
        .addr_load  (addr_load),
        .addr_shift (addr_shift),
        .data_load  (data_load),
        .data_shift (data_shift),
        .byte_sel   (byte_sel),
        .byte_take  (byte_take),
        .busy       (busy),
        .done       (done),
        .err        (err),
        .rst_step   (rst_step)
    );

    pew_bus_cycle #(
        .STROBE_CLKS (STROBE_CLKS),
        .GAP_CLKS    (GAP_CLKS)
    ) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_start (cyc_start),
        .cyc_write (cyc_write),
        .cyc_bit   (cyc_bit),
        .dq_i      (mem_dq_i),
        .idle      (eng_idle),
        .cyc_done  (cyc_done),
        .rd_bit    (rd_bit),
        .sel_n     (mem_sel_n),
        .rd_n      (mem_rd_n),
        .wr_n      (mem_wr_n),
        .dq_o      (mem_dq_o),
        .dq_oe     (mem_dq_oe)
    );

    pew_shreg #(.W(ADDR_W)) u_addr_sr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (addr_load),
        .shift (addr_shift),
        .din   (req_addr),
        .msb   (addr_msb)
    );

    pew_shreg #(.W(BYTE_BITS)) u_data_sr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (data_load),
        .shift (data_shift),
        .din   (byte_data),
        .msb   (data_msb)
    );

endmodule

// File: rtl/pew_sequencer_chk.sv
// Module: protocol checker for pew_sequencer, attached by bind.
// Assumes: reset is low for at least one clock before operation.
module pew_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic err,
    input logic rst_step,
    input logic mem_sel_n,
    input logic mem_rd_n,
    input logic mem_wr_n,
    input logic mem_dq_o,
    input logic mem_dq_oe
);

    // R3: a write strobe only occurs with select low and no read strobe.
    a_r3_write_shape: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |-> (!mem_sel_n && mem_rd_n));

    // R6: a read strobe only occurs with select low and no write strobe.
    a_r6_read_shape: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_n |-> (!mem_sel_n && mem_wr_n));

    // R8: the pin is only driven under a write strobe.
    a_r8_oe_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> !mem_wr_n);

    // R7: a released select stays high for at least one more clock.
    a_r7_gap_held: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_sel_n) |=> mem_sel_n);

    // R7: strobe type and data bit are steady within a strobe.
    a_r7_strobe_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_sel_n && !$fell(mem_sel_n)) |->
            ($stable(mem_wr_n) && $stable(mem_dq_o)));

    // R2: a refusal happens with no transaction and no bus cycle.
    a_r2_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && mem_sel_n));

    // R1: the reset step is inside a transaction, outside any bus cycle.
    a_r1_rst_step: assert property (@(posedge clk) disable iff (!rst_n)
        rst_step |-> (busy && mem_sel_n));

    // R10: with no transaction the bus is quiet.
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mem_sel_n && !mem_dq_oe));

    // R6: busy falls right after done.
    a_r6_done_release: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R9: busy holds until done, whatever requests arrive.
    a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

endmodule

bind pew_sequencer pew_sequencer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .rst_step  (rst_step),
    .mem_sel_n (mem_sel_n),
    .mem_rd_n  (mem_rd_n),
    .mem_wr_n  (mem_wr_n),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/pew_sequencer_tb.sv
// Bench: directed scenarios for pew_sequencer, one task each.
module pew_sequencer_tb;

    localparam int MAXC = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic [5:0] req_count = '0;
    logic [4:0] byte_sel;
    logic       byte_take;
    logic [7:0] byte_data;
    logic       busy, done, err, rst_step;
    logic       mem_sel_n, mem_rd_n, mem_wr_n, mem_dq_o, mem_dq_oe;
    logic       mem_dq_i = 1'b0;

    logic [7:0] pay [0:31];
    assign byte_data = pay[byte_sel];

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    // Monitor state (written only by the monitor process).
    logic cyc_wr [0:MAXC-1];
    logic cyc_bit [0:MAXC-1];
    int   take_idx [0:63];
    int   ncyc, ntake, rd_seen, rst_cnt, rst_at;
    int   low_run, hi_run, width_bad, gap_bad, oe_bad;
    logic prev_sel = 1'b1;
    logic clr_req = 1'b0;
    int   poll_zeros = 0;

    always #10 clk = ~clk;

    pew_sequencer u_dut (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid),
        .req_addr (req_addr), .req_count (req_count),
        .byte_sel (byte_sel), .byte_take (byte_take), .byte_data (byte_data),
        .busy (busy), .done (done), .err (err), .rst_step (rst_step),
        .mem_sel_n (mem_sel_n), .mem_rd_n (mem_rd_n), .mem_wr_n (mem_wr_n),
        .mem_dq_o (mem_dq_o), .mem_dq_oe (mem_dq_oe), .mem_dq_i (mem_dq_i)
    );

    // Bus monitor and memory pin model, sampled on the falling edge.
    always @(negedge clk) begin
        if (clr_req || !rst_n) begin
            ncyc = 0; ntake = 0; rd_seen = 0; rst_cnt = 0; rst_at = -1;
            low_run = 0; hi_run = 100; width_bad = 0; gap_bad = 0; oe_bad = 0;
            prev_sel = 1'b1; mem_dq_i = 1'b0;
        end else begin
            if (mem_dq_oe && mem_wr_n) oe_bad++;
            if (!mem_sel_n && prev_sel) begin
                if (hi_run < 1) gap_bad++;
                if (ncyc < MAXC) begin
                    cyc_wr[ncyc]  = !mem_wr_n;
                    cyc_bit[ncyc] = mem_dq_o;
                end
                if (mem_wr_n) begin
                    rd_seen++;
                    mem_dq_i = (rd_seen >= 3 + poll_zeros);
                end
                ncyc++;
                low_run = 1;
            end else if (!mem_sel_n) begin
                low_run++;
            end else if (prev_sel == 1'b0) begin
                if (low_run != 2) width_bad++;
                hi_run = 1;
            end else begin
                hi_run++;
            end
            if (rst_step) begin
                rst_cnt++;
                rst_at = ncyc;
            end
            if (byte_take && ntake < 64) begin
                take_idx[ntake] = int'(byte_sel);
                ntake++;
            end
            prev_sel = mem_sel_n;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        clr_req = 1'b1;
        repeat (2) @(posedge clk);
        clr_req = 1'b0;
    endtask

    // R10: quiet bus and flags after reset.
    task automatic t_reset();
        @(negedge clk);
        chk(mem_sel_n && mem_rd_n && mem_wr_n, "R10 strobes high",
            {mem_sel_n, mem_rd_n, mem_wr_n}, 7);
        chk(!mem_dq_oe, "R10 oe low", mem_dq_oe, 0);
        chk(!busy && !done && !err, "R10 flags low", {busy, done, err}, 0);
    endtask

    // R2: refused request, no bus activity.
    task automatic t_bad(input int cnt);
        clear_mon();
        @(negedge clk);
        req_valid = 1'b1; req_addr = 16'hBEEF; req_count = 6'(cnt);
        @(negedge clk);
        req_valid = 1'b0;
        chk(err && !busy, "R2 err pulse", {err, busy}, 2);
        repeat (20) @(negedge clk);
        chk(!err && !busy, "R2 err one clock, no busy", {err, busy}, 0);
        chk(ncyc == 0, "R2 no bus cycles", ncyc, 0);
    endtask

    // R1 R3 R4 R5 R6 R7 R8 (and R9 when intrude is set): one full transaction.
    task automatic t_write(input logic [15:0] addr, input int n, input int pz,
                           input bit intrude);
        int base, bad, first, waited;
        for (int i = 0; i < 32; i++) pay[i] = 8'(i * 37) ^ addr[7:0] ^ 8'hA5;
        poll_zeros = pz;
        clear_mon();
        @(negedge clk);
        req_valid = 1'b1; req_addr = addr; req_count = 6'(n);
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy && !err, "R1 busy after accept", {busy, err}, 2);
        if (intrude) begin
            repeat (5) @(negedge clk);
            req_valid = 1'b1; req_addr = ~addr; req_count = 6'd1;
            @(negedge clk);
            req_valid = 1'b0;
            chk(busy && !err, "R9 intruding request ignored", {busy, err}, 2);
        end
        waited = 0;
        while (!done && waited < 20000) begin
            @(negedge clk);
            waited++;
        end
        chk(done == 1'b1, "R6 done pulse", done, 1);
        @(negedge clk);
        chk(!busy && !done, "R6 busy falls after done", {busy, done}, 0);
        chk(rst_cnt == 1 && rst_at == 0, "R1 single reset step before bus",
            rst_cnt * 1000 + rst_at, 1000);
        chk(ncyc == 16 + 8 * n + 4 + pz, "R6 cycle count", ncyc, 16 + 8 * n + 4 + pz);
        bad = 0; first = -1;
        for (int i = 0; i < 16; i++)
            if (!cyc_wr[i] || cyc_bit[i] != addr[15 - i]) begin
                bad++; if (first < 0) first = i;
            end
        chk(bad == 0, intrude ? "R3 R9 address bits" : "R3 address bits", first, -1);
        bad = 0; first = -1;
        for (int i = 0; i < 8 * n; i++)
            if (!cyc_wr[16 + i] || cyc_bit[16 + i] != pay[i / 8][7 - (i % 8)]) begin
                bad++; if (first < 0) first = i;
            end
        chk(bad == 0, "R4 data bits", first, -1);
        bad = (ntake != n) ? 1 : 0;
        for (int i = 0; i < n && i < ntake; i++) if (take_idx[i] != i) bad++;
        chk(bad == 0, "R4 byte take order", ntake, n);
        base = 16 + 8 * n;
        chk(!cyc_wr[base] && cyc_wr[base + 1] && cyc_bit[base + 1] && !cyc_wr[base + 2],
            "R5 read/write-1/read trigger",
            {cyc_wr[base], cyc_wr[base + 1], cyc_bit[base + 1], cyc_wr[base + 2]}, 6);
        bad = 0;
        for (int i = base + 3; i < ncyc && i < MAXC; i++) if (cyc_wr[i]) bad++;
        chk(bad == 0 && rd_seen == 3 + pz, "R6 polls are reads until high", rd_seen, 3 + pz);
        chk(width_bad == 0 && gap_bad == 0, "R7 strobe width and gap",
            width_bad + gap_bad, 0);
        chk(oe_bad == 0, "R8 oe only in writes", oe_bad, 0);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) pay[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write(16'h8001, 1, 0, 1'b0);
        t_write(16'h5A3C, 3, 2, 1'b0);
        t_bad(0);
        t_bad(33);
        t_bad(63);
        t_write(16'hFFE0, 32, 1, 1'b0);
        t_write(16'h1234, 2, 3, 1'b1);
        t_write(16'h0F0F, 5, 0, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule